// File: doc/BRIEF.md
# PLL Frequency Lock Detector and Loop Bandwidth Controller

This block watches a phase-locked loop from the digital side. It divides the VCO clock by a programmable factor N to form the feedback clock. It counts the feedback edges that arrive within a measurement window, where the window is timed by the reference clock. Each finished window is sorted into one of three classes by how far its count lies from the expected count: in tolerance, marginal, or far off.

The window results drive a two-state loop bandwidth setting. In acquisition the loop filter may make large corrections. In tracking it may make only small ones. The results also drive a lock flag, which tells software that the VCO clock is now safe to select as the base clock.

In automatic mode the detector moves between acquisition and tracking on its own. In manual mode software holds the bandwidth bit directly. A sticky interrupt flag records each change of the lock flag while interrupts are enabled. Software clears the flag with a one-cycle write-one-to-clear strobe.

The analog phase detector, loop filter and VCO are outside this block. The reference clock is divided internally by `REF_DIV` to give the final reference. A window lasts `WIN_LEN` final-reference periods, and the expected count is `WIN_LEN`.

Top module: `pll_lockdet`

## Requirements
- R1: The feedback clock runs at the VCO frequency divided by `div_n`, with 0 treated as 1. A window lasts `WIN_LEN*REF_DIV` reference cycles (128 by default) and expects `WIN_LEN` (32) feedback periods. A VCO that gives 32 feedback periods at N=8 therefore measures as far off at N=10.
- R2: While `rst` is high at a reference clock edge, `track_o`, `lock_o` and `irq_o` are 0 after that edge. `track_o` = 0 means acquisition and 1 means tracking.
- R3: In automatic mode (`auto_bw` = 1), while in acquisition, two consecutive windows with a count error of at most 1 switch `track_o` to 1 at the end of the second window. One such window alone leaves acquisition in place.
- R4: In automatic mode, while tracking, a window with an error greater than 4 returns `track_o` to 0.
- R5: While tracking, a window with an error of 2 to 4 leaves `track_o` unchanged and clears `lock_o`.
- R6: `lock_o` becomes 1 at the end of the fourth consecutive in-tolerance window counted while tracking. From acquisition in automatic mode, that is the end of the sixth in-tolerance window.
- R7: `lock_o` is never 1 while `track_o` is 0. When tracking ends, by a far-off window or by a software write, `lock_o` clears in the same cycle.
- R8: In manual mode (`auto_bw` = 0), `track_o` takes the value of `sw_track` one cycle later, and window results do not change the mode.
- R9: With `irq_en` = 1, each change of `lock_o` sets `irq_o`. `irq_o` stays set until an `irq_clr` pulse. A new lock change in the same cycle as a clear wins over the clear.
- R10: With `irq_en` = 0, changes of `lock_o` leave `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all control and status run on it |
| vco_clk | input | 1 | VCO clock to be divided |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| div_n | input | DIV_W | Feedback divide factor N, quasi-static |
| auto_bw | input | 1 | 1 = automatic bandwidth switching, 0 = manual |
| sw_track | input | 1 | Manual bandwidth bit: 1 = tracking, 0 = acquisition |
| irq_en | input | 1 | Enable for lock-change interrupts |
| irq_clr | input | 1 | One-cycle strobe that clears the interrupt flag |
| track_o | output | 1 | Bandwidth state: 1 = tracking, 0 = acquisition |
| lock_o | output | 1 | Lock flag; VCO clock safe to use |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The hardest state to reach from the ports is a window whose count lands in a chosen error band. The count depends on the ratio of two free-running clocks, on N, and on where the window boundaries fall. The bench sets the VCO half period from the target count and N. It makes every frequency and control change two reference cycles before a window closes, so that each window sees only one frequency. The target counts (32, 35, 44) lie well inside the three bands, so the one-edge phase uncertainty cannot move a window across a band edge. A bench model then predicts mode, lock and interrupt for each window, under a directed sequence followed by seeded random mixes of bands and controls.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;

    localparam int MEAS_W = 16;

    typedef enum logic [1:0] {
        WIN_GOOD,
        WIN_MID,
        WIN_BAD
    } win_cls_e;

    typedef struct packed {
        logic              valid;
        logic [MEAS_W-1:0] count;
    } meas_t;

    function automatic logic [MEAS_W-1:0] abs_diff(input logic [MEAS_W-1:0] a,
                                                   input logic [MEAS_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic win_cls_e classify(input logic [MEAS_W-1:0] err,
                                          input logic [MEAS_W-1:0] good_tol,
                                          input logic [MEAS_W-1:0] bad_tol);
        if (err <= good_tol)
            return WIN_GOOD;
        else if (err > bad_tol)
            return WIN_BAD;
        else
            return WIN_MID;
    endfunction

endpackage

// File: rtl/pll_fb_divider.sv
module pll_fb_divider #(
    parameter int DIV_W = 8
) (
    input  logic             vco_clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    output logic             fb_tgl
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    // one toggle per feedback period; N = 0 behaves as N = 1
    assign last = (div_n == '0) ? '0 : div_n - 1'b1;

    always_ff @(posedge vco_clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fb_tgl <= 1'b0;
        end else if (cnt_q >= last) begin
            cnt_q  <= '0;
            fb_tgl <= ~fb_tgl;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pll_edge_sync.sv
module pll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic edge_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b0;
                else     chain_q[0] <= tgl_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= chain_q[STAGES-1];
    end

    assign edge_pulse = chain_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/pll_window_meter.sv
module pll_window_meter
    import pll_ld_pkg::*;
#(
    parameter int WIN_CYC = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  edge_pulse,
    output meas_t meas
);
    localparam int CYC_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(WIN_CYC - 1);

    logic [CYC_W-1:0]  cyc_q;
    logic [MEAS_W-1:0] edges_q;
    logic [MEAS_W-1:0] edges_inc;

    assign edges_inc = (edge_pulse && edges_q != '1) ? edges_q + 1'b1 : edges_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= '0;
            edges_q <= '0;
            meas    <= '0;
        end else if (cyc_q == CYC_LAST) begin
            cyc_q       <= '0;
            edges_q     <= '0;
            meas.valid  <= 1'b1;
            meas.count  <= edges_inc;
        end else begin
            cyc_q       <= cyc_q + 1'b1;
            edges_q     <= edges_inc;
            meas.valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_bw_ctrl.sv
module pll_bw_ctrl
    import pll_ld_pkg::*;
#(
    parameter int WIN_LEN   = 32,
    parameter int ACQ_WINS  = 2,
    parameter int LOCK_WINS = 4,
    parameter int GOOD_TOL  = 1,
    parameter int BAD_TOL   = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  meas_t meas,
    input  logic  auto_bw,
    input  logic  sw_track,
    input  logic  irq_en,
    input  logic  irq_clr,
    output logic  track_o,
    output logic  lock_o,
    output logic  irq_o
);
    localparam int GS_W = (ACQ_WINS > 2) ? $clog2(ACQ_WINS) : 1;
    localparam int LC_W = (LOCK_WINS > 2) ? $clog2(LOCK_WINS) : 1;
    localparam logic [GS_W-1:0] GS_LAST = GS_W'(ACQ_WINS - 1);
    localparam logic [LC_W-1:0] LC_LAST = LC_W'(LOCK_WINS - 1);

    logic [GS_W-1:0] gs_q, gs_d;
    logic [LC_W-1:0] lc_q, lc_d;
    logic            trk_q, trk_d;
    logic            lock_q, lock_d;
    logic            irq_q, irq_d;
    win_cls_e        cls;

    assign cls = classify(abs_diff(meas.count, MEAS_W'(WIN_LEN)),
                          MEAS_W'(GOOD_TOL), MEAS_W'(BAD_TOL));

    always_comb begin
        trk_d  = trk_q;
        gs_d   = gs_q;
        lc_d   = lc_q;
        lock_d = lock_q;
        if (!auto_bw) begin
            trk_d = sw_track;
            gs_d  = '0;
        end
        if (meas.valid) begin
            if (trk_q) begin
                if (cls == WIN_GOOD) begin
                    if (lc_q == LC_LAST) lock_d = 1'b1;
                    else                 lc_d   = lc_q + 1'b1;
                end else begin
                    lc_d   = '0;
                    lock_d = 1'b0;
                end
                if (auto_bw && cls == WIN_BAD) begin
                    trk_d = 1'b0;
                    gs_d  = '0;
                end
            end else if (auto_bw) begin
                if (cls == WIN_GOOD) begin
                    if (gs_q == GS_LAST) begin
                        trk_d = 1'b1;
                        gs_d  = '0;
                    end else begin
                        gs_d = gs_q + 1'b1;
                    end
                end else begin
                    gs_d = '0;
                end
            end
        end
        // lock never outlives tracking
        if (!trk_d) begin
            lc_d   = '0;
            lock_d = 1'b0;
        end
        if (irq_en && (lock_d != lock_q))
            irq_d = 1'b1;
        else if (irq_clr)
            irq_d = 1'b0;
        else
            irq_d = irq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q  <= 1'b0;
            gs_q   <= '0;
            lc_q   <= '0;
            lock_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            trk_q  <= trk_d;
            gs_q   <= gs_d;
            lc_q   <= lc_d;
            lock_q <= lock_d;
            irq_q  <= irq_d;
        end
    end

    assign track_o = trk_q;
    assign lock_o  = lock_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/pll_lockdet.sv
module pll_lockdet
    import pll_ld_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int WIN_LEN     = 32,
    parameter int REF_DIV     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ACQ_WINS    = 2,
    parameter int LOCK_WINS   = 4,
    parameter int GOOD_TOL    = 1,
    parameter int BAD_TOL     = 4
) (
    input  logic             ref_clk,
    input  logic             vco_clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    input  logic             auto_bw,
    input  logic             sw_track,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic             track_o,
    output logic             lock_o,
    output logic             irq_o
);
    localparam int WIN_CYC = WIN_LEN * REF_DIV;

    logic  fb_tgl;
    logic  fb_pulse;
    meas_t meas;
    logic  win_done;

    pll_fb_divider #(.DIV_W(DIV_W)) u_div (
        .vco_clk (vco_clk),
        .rst     (rst),
        .div_n   (div_n),
        .fb_tgl  (fb_tgl)
    );

    pll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (ref_clk),
        .rst        (rst),
        .tgl_in     (fb_tgl),
        .edge_pulse (fb_pulse)
    );

    pll_window_meter #(.WIN_CYC(WIN_CYC)) u_meter (
        .clk        (ref_clk),
        .rst        (rst),
        .edge_pulse (fb_pulse),
        .meas       (meas)
    );

    pll_bw_ctrl #(
        .WIN_LEN   (WIN_LEN),
        .ACQ_WINS  (ACQ_WINS),
        .LOCK_WINS (LOCK_WINS),
        .GOOD_TOL  (GOOD_TOL),
        .BAD_TOL   (BAD_TOL)
    ) u_ctrl (
        .clk      (ref_clk),
        .rst      (rst),
        .meas     (meas),
        .auto_bw  (auto_bw),
        .sw_track (sw_track),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .track_o  (track_o),
        .lock_o   (lock_o),
        .irq_o    (irq_o)
    );

    assign win_done = meas.valid;
endmodule

// File: rtl/pll_lockdet_chk.sv
module pll_lockdet_chk (
    input logic ref_clk,
    input logic rst,
    input logic auto_bw,
    input logic sw_track,
    input logic irq_en,
    input logic irq_clr,
    input logic track_o,
    input logic lock_o,
    input logic irq_o,
    input logic win_done
);
    p_reset_clear_r2: assert property (@(posedge ref_clk)
        rst |=> (!track_o && !lock_o && !irq_o));

    p_auto_track_at_window_r3: assert property (@(posedge ref_clk) disable iff (rst)
        ($rose(track_o) && $past(auto_bw)) |-> $past(win_done));

    p_lock_at_window_r6: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(lock_o) |-> $past(win_done));

    p_lock_needs_track_r7: assert property (@(posedge ref_clk) disable iff (rst)
        lock_o |-> track_o);

    p_manual_follows_r8: assert property (@(posedge ref_clk) disable iff (rst)
        !auto_bw |=> (track_o == $past(sw_track)));

    p_irq_sticky_r9: assert property (@(posedge ref_clk) disable iff (rst)
        (irq_o && !irq_clr) |=> irq_o);

    p_irq_on_lock_change_r9: assert property (@(posedge ref_clk) disable iff (rst)
        ($past(irq_en) && (lock_o != $past(lock_o))) |-> irq_o);

    p_irq_quiet_r10: assert property (@(posedge ref_clk) disable iff (rst)
        (!irq_en && !irq_o) |=> !irq_o);
endmodule

bind pll_lockdet pll_lockdet_chk u_chk (
    .ref_clk  (ref_clk),
    .rst      (rst),
    .auto_bw  (auto_bw),
    .sw_track (sw_track),
    .irq_en   (irq_en),
    .irq_clr  (irq_clr),
    .track_o  (track_o),
    .lock_o   (lock_o),
    .irq_o    (irq_o),
    .win_done (win_done)
);

// File: tb/sim_pll_lockdet.sv
module sim_pll_lockdet;
    localparam int CLK_PERIOD = 10000;
    localparam int CG = 0, CM = 1, CB = 2;

    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_n = 8'd8;
    logic       auto_bw = 1'b1, sw_track = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
    logic       track_o, lock_o, irq_o;
    int         vhalf = 2500;
    int         n_tests = 0, n_fail = 0;

    // bench model state
    bit m_trk, m_lock, m_irq;
    int m_gs, m_lc, prev_cls;

    pll_lockdet u0 (
        .ref_clk (ref_clk), .vco_clk (vco_clk), .rst (rst), .div_n (div_n),
        .auto_bw (auto_bw), .sw_track (sw_track), .irq_en (irq_en),
        .irq_clr (irq_clr), .track_o (track_o), .lock_o (lock_o), .irq_o (irq_o)
    );

    initial forever #(CLK_PERIOD/2) ref_clk = ~ref_clk;
    initial forever #(vhalf) vco_clk = ~vco_clk;

    // VCO half period giving about cnt feedback periods per 128-cycle window
    function automatic int hp(input int cls, input int n);
        int c;
        c = (cls == CG) ? 32 : (cls == CM) ? 35 : 44;
        return (CLK_PERIOD * 64) / (c * n);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic model_step(input int cls, input bit au, input bit sw, input bit ie);
        bit t, nt, old_lock;
        int ngs;
        old_lock = m_lock;
        t   = au ? m_trk : sw;
        nt  = t;
        ngs = au ? m_gs : 0;
        if (t) begin
            if (cls == CG) begin
                if (m_lc == 3) m_lock = 1'b1;
                else           m_lc++;
            end else begin
                m_lc = 0; m_lock = 1'b0;
            end
            if (au && cls == CB) begin nt = 1'b0; ngs = 0; end
        end else if (au) begin
            if (cls == CG) begin
                if (m_gs == 1) begin nt = 1'b1; ngs = 0; end
                else ngs = m_gs + 1;
            end else ngs = 0;
        end
        if (!nt) begin m_lc = 0; m_lock = 1'b0; end
        m_trk = nt;
        m_gs  = ngs;
        if (ie && (m_lock != old_lock)) m_irq = 1'b1;
    endtask

    task automatic do_reset(input int cls, input int n);
        rst = 1'b1; irq_clr = 1'b0;
        div_n = 8'(n); vhalf = hp(cls, n);
        repeat (8) @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R2", "track in reset", track_o, 1'b0);
        chk("R2", "lock in reset", lock_o, 1'b0);
        chk("R2", "irq in reset", irq_o, 1'b0);
        @(posedge ref_clk); #1 rst = 1'b0;
        m_trk = 0; m_lock = 0; m_irq = 0; m_gs = 0; m_lc = 0;
        prev_cls = cls;
        repeat (126) @(posedge ref_clk);
        #1;
    endtask

    // called two cycles before a window closes; sets the next window's stimulus
    task automatic win(input string req, input int cls, input int n, input bit au,
                       input bit sw, input bit ie, input bit clr, input int half_ovr);
        auto_bw = au; sw_track = sw; irq_en = ie;
        div_n = 8'(n);
        vhalf = (half_ovr > 0) ? half_ovr : hp(cls, n);
        repeat (66) @(posedge ref_clk);
        model_step(prev_cls, au, sw, ie);
        prev_cls = cls;
        @(negedge ref_clk);
        chk(req, "track_o", track_o, m_trk);
        chk(req, "lock_o", lock_o, m_lock);
        chk(req, "irq_o", irq_o, m_irq);
        if (clr) begin
            @(posedge ref_clk); #1 irq_clr = 1'b1;
            @(posedge ref_clk); #1 irq_clr = 1'b0;
            m_irq = 1'b0;
            repeat (60) @(posedge ref_clk);
        end else begin
            repeat (62) @(posedge ref_clk);
        end
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge ref_clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int rn;
        void'($urandom(32'd1234));

        // directed: automatic acquisition to lock, N = 8
        do_reset(CG, 8);
        win("R3", CG, 8, 1, 0, 1, 0, 0);   // one good window: still acquiring
        win("R3", CG, 8, 1, 0, 1, 0, 0);   // second good window: tracking
        for (int i = 0; i < 3; i++) win("R6", CG, 8, 1, 0, 1, 0, 0);
        win("R6", CM, 8, 1, 0, 1, 0, 0);   // sixth good window: lock, irq
        win("R5", CG, 8, 1, 0, 1, 1, 0);   // marginal window: lock clears, still tracking
        for (int i = 0; i < 3; i++) win("R9", CG, 8, 1, 0, 1, 0, 0);
        win("R9", CB, 8, 1, 0, 1, 0, 0);   // relock raises irq again
        win("R4", CG, 8, 1, 0, 1, 1, 0);   // far-off window: back to acquisition
        // interrupts disabled through a full relock
        for (int i = 0; i < 7; i++) win("R10", CG, 8, 1, 0, 0, 0, 0);
        // manual mode
        for (int i = 0; i < 3; i++) win("R8", CG, 8, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) win("R8", CG, 8, 0, 1, 0, 0, 0);
        win("R7", CG, 8, 0, 0, 1, 0, 0);   // software drops tracking: lock drops
        win("R7", CG, 8, 0, 0, 1, 1, 0);
        // divider: same VCO, N raised to 10 measures far off
        for (int i = 0; i < 7; i++) win("R1", CG, 8, 1, 0, 0, 0, 0);
        win("R1", CB, 10, 1, 0, 0, 0, hp(CG, 8));
        win("R1", CB, 10, 1, 0, 0, 0, hp(CG, 8));
        win("R1", CG, 10, 1, 0, 0, 0, 0);

        // random phases, N fixed per reset
        for (int seg = 0; seg < 3; seg++) begin
            rn = 4 + int'($urandom % 7);
            do_reset(CG, rn);
            for (int i = 0; i < 30; i++) begin
                int  c;
                bit  au, sw, ie, cl;
                c  = int'($urandom % 4);
                c  = (c >= 2) ? CG : (c == 1 ? CM : CB);
                if (($urandom % 3) == 0) c = CB - 2 * int'($urandom % 2); // extra extremes
                au = ($urandom % 6) != 0;
                sw = $urandom % 2;
                ie = $urandom % 2;
                cl = ($urandom % 4) == 0;
                win("R1", c, rn, au, sw, ie, cl, 0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule